// File: doc/BRIEF.md
# Scan-Out Control Register Bank

This block is the software-visible configuration store for a raster display engine. A processor reaches it through a small 32-bit slave port with separate read and write strobes and byte enables. It keeps the horizontal and vertical timing words, the frame start address, the fetch burst length, a display-data-channel control word and a pixel clock source selector. All of these are driven as steady levels to a timing generator and a pixel fetcher that sit outside this block.

Bit 0 of the control word holds the display in reset. The enable level is the inverse of that bit. When a write to the control or resolution words leaves the display enabled, the block emits a resize pulse and an invalidate pulse. Accepted writes to the frame start address also emit an invalidate pulse. The fetcher receives the stored frame address plus a fixed build-time byte offset, and a line stride of two bytes per pixel. Illegal accesses raise a one-cycle error pulse. These are misaligned frame addresses, writes to the read-only address view, partial-width accesses and unmapped offsets.

Top module: `fbctl_regfile`

## Requirements
- R1: After reset, the control word reads 1 and the display is disabled. The horizontal active width reads 640 and the vertical active height reads 480. Every other stored word reads 0.
- R2: Byte address bits [5:2] select the word: 0 control, 1 h-active, 2 h-sync begin, 3 h-sync end, 4 h-total, 5 v-active, 6 v-sync begin, 7 v-sync end, 8 v-total, 9 frame base, 10 frame base view, 11 burst length, 12 DDC control, 13 clock select. A legal write to a read/write word stores the data. The data reads back and appears on the matching output port.
- R3: Every strobed access gives bus_ack high for exactly one cycle, on the cycle after the strobe. Read data is valid in that same cycle. A read strobed together with a write is ignored.
- R4: disp_enable is high exactly while bit 0 of the control word is 0.
- R5: A frame base write with any of bits [4:0] set is rejected. The stored value is unchanged, err_pulse is raised, and no invalidate pulse follows.
- R6: An accepted frame base write stores the data ANDed with parameter BASE_MASK and raises inval_pulse for one cycle.
- R7: Reading word 10 returns the current frame base. Writing word 10 changes nothing and raises err_pulse.
- R8: A legal write to the control, h-active or v-active word raises resize_pulse and inval_pulse when the display is enabled after the write. No pulse is raised when the display is disabled after the write.
- R9: An access is illegal when its byte enables are not all ones, when address bits [1:0] are nonzero, or when it targets word 14 or 15. An illegal access stores nothing, returns read data 0 and raises err_pulse.
- R10: line_stride equals the h-active word multiplied by 2.
- R11: fetch_base equals the frame base word plus parameter FETCH_OFFSET.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_be | input | DATA_W/8 | Byte enables, all ones required |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid with bus_ack |
| bus_ack | output | 1 | Access completion, one cycle after the strobe |
| err_pulse | output | 1 | Illegal access pulse |
| resize_pulse | output | 1 | Geometry change pulse |
| inval_pulse | output | 1 | Frame contents invalidate pulse |
| disp_enable | output | 1 | Display enable level |
| h_active | output | DATA_W | Horizontal active pixels |
| hs_begin | output | DATA_W | Horizontal sync start |
| hs_end | output | DATA_W | Horizontal sync end |
| h_total | output | DATA_W | Horizontal total |
| v_active | output | DATA_W | Vertical active lines |
| vs_begin | output | DATA_W | Vertical sync start |
| vs_end | output | DATA_W | Vertical sync end |
| v_total | output | DATA_W | Vertical total |
| fetch_base | output | DATA_W | Frame base plus fetch offset |
| line_stride | output | DATA_W | Bytes per line |
| burst_len | output | DATA_W | Fetch burst length |
| ddc_ctl | output | DATA_W | Display data channel control |
| clk_sel | output | DATA_W | Pixel clock source select |

## Verification
The bench builds the block with BASE_MASK = 32'h00FF_FFFF and FETCH_OFFSET = 32'h400, and leaves the 6-bit address and 32-bit data at their defaults. The narrowed mask makes the masking of an accepted frame base write visible, because it clears address bits that a full mask would keep. The nonzero offset separates fetch_base from the stored base. With the defaults, the 6-bit address reaches the two unmapped words 14 and 15.

// File: rtl/fbctl_pkg.sv
package fbctl_pkg;
  localparam int NREG       = 14;
  localparam int IDX_W      = 4;
  localparam int ALIGN_BITS = 5;

  typedef enum logic [IDX_W-1:0] {
    IX_CTL    = 4'd0,
    IX_HACT   = 4'd1,
    IX_HSB    = 4'd2,
    IX_HSE    = 4'd3,
    IX_HTOT   = 4'd4,
    IX_VACT   = 4'd5,
    IX_VSB    = 4'd6,
    IX_VSE    = 4'd7,
    IX_VTOT   = 4'd8,
    IX_BASE   = 4'd9,
    IX_VIEW   = 4'd10,
    IX_BURST  = 4'd11,
    IX_DDC    = 4'd12,
    IX_CLKSEL = 4'd13
  } reg_idx_e;
endpackage

// File: rtl/fbctl_decode.sv
module fbctl_decode
  import fbctl_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int STRB_W = 4
) (
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  wr,
  input  logic                  rd,
  input  logic [STRB_W-1:0]     be,
  input  logic [ALIGN_BITS-1:0] wdata_lo,
  output logic [IDX_W-1:0]      idx,
  output logic                  wr_ok,
  output logic                  rd_ok,
  output logic                  bad_acc
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic              in_map;
  logic              full;
  logic              base_misal;
  logic              ro_hit;

  always_comb begin
    word       = addr[ADDR_W-1:2];
    idx        = word[IDX_W-1:0];
    in_map     = (word < WORD_W'(NREG)) && (addr[1:0] == 2'b00);
    full       = &be;
    base_misal = (idx == IX_BASE) && (|wdata_lo);
    ro_hit     = (idx == IX_VIEW);
    wr_ok      = wr && full && in_map && !ro_hit && !base_misal;
    rd_ok      = rd && !wr && full && in_map;
    bad_acc    = (wr && !wr_ok) || (rd && !wr && !rd_ok);
  end
endmodule

// File: rtl/fbctl_regbank.sv
module fbctl_regbank
  import fbctl_pkg::*;
#(
  parameter int          DATA_W    = 32,
  parameter logic [31:0] BASE_MASK = 32'hFFFF_FFFF,
  parameter int          RST_HACT  = 640,
  parameter int          RST_VACT  = 480
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_req,
  input  logic                        wr_ok,
  input  logic [IDX_W-1:0]            idx,
  input  logic [DATA_W-1:0]           wdata,
  output logic [NREG-1:0][DATA_W-1:0] regs_o,
  output logic                        res_evt,
  output logic                        base_evt
);
  localparam logic [DATA_W-1:0] MASK_W = DATA_W'(BASE_MASK);

  for (genvar g = 0; g < NREG; g++) begin : g_slot
    if (g == int'(IX_VIEW)) begin : g_view
      assign regs_o[g] = '0;
    end else begin : g_store
      localparam logic [DATA_W-1:0] RV =
        (g == int'(IX_CTL))  ? DATA_W'(1)        :
        (g == int'(IX_HACT)) ? DATA_W'(RST_HACT) :
        (g == int'(IX_VACT)) ? DATA_W'(RST_VACT) : '0;

      logic [DATA_W-1:0] q;
      logic [DATA_W-1:0] d;
      logic [DATA_W-1:0] din;
      logic              we;

      always_comb begin
        we  = wr_ok && (idx == IDX_W'(g));
        din = (g == int'(IX_BASE)) ? (wdata & MASK_W) : wdata;
        d   = we ? din : q;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RV;
        else        q <= d;
      end

      assign regs_o[g] = q;
    end
  end

  logic geo_hit;
  logic ctl_bit_next;

  always_comb begin
    geo_hit      = (idx == IX_CTL) || (idx == IX_HACT) || (idx == IX_VACT);
    ctl_bit_next = (wr_ok && idx == IX_CTL) ? wdata[0] : regs_o[IX_CTL][0];
    res_evt      = wr_ok && geo_hit && !ctl_bit_next;
    base_evt     = wr_ok && (idx == IX_BASE);
  end

  // R5
  base_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    regs_o[IX_BASE][ALIGN_BITS-1:0] == '0);

  // R7
  view_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && idx == IX_VIEW) |=> $stable(regs_o[IX_BASE]));
endmodule

// File: rtl/fbctl_rdmux.sv
module fbctl_rdmux
  import fbctl_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rd_req,
  input  logic                        rd_ok,
  input  logic [IDX_W-1:0]            idx,
  input  logic [NREG-1:0][DATA_W-1:0] regs,
  output logic [DATA_W-1:0]           rdata_o
);
  logic [DATA_W-1:0] sel;
  logic [DATA_W-1:0] rdata_d;

  always_comb begin
    sel = '0;
    for (int i = 0; i < NREG; i++) begin
      if (idx == IDX_W'(i)) sel = regs[i];
    end
    if (idx == IX_VIEW) sel = regs[IX_BASE];
    rdata_d = rd_ok ? sel : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_o <= '0;
    else        rdata_o <= rdata_d;
  end

  // R9
  bad_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ok) |=> (rdata_o == '0));
endmodule

// File: rtl/fbctl_events.sv
module fbctl_events (
  input  logic clk,
  input  logic rst_n,
  input  logic acc,
  input  logic res_evt,
  input  logic base_evt,
  input  logic bad_acc,
  output logic ack_q,
  output logic resize_q,
  output logic inval_q,
  output logic err_q
);
  logic ack_d, resize_d, inval_d, err_d;

  always_comb begin
    ack_d    = acc;
    resize_d = res_evt;
    inval_d  = res_evt || base_evt;
    err_d    = bad_acc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q    <= 1'b0;
      resize_q <= 1'b0;
      inval_q  <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      ack_q    <= ack_d;
      resize_q <= resize_d;
      inval_q  <= inval_d;
      err_q    <= err_d;
    end
  end
endmodule

// File: rtl/fbctl_regfile.sv
module fbctl_regfile
  import fbctl_pkg::*;
#(
  parameter int          ADDR_W        = 6,
  parameter int          DATA_W        = 32,
  parameter logic [31:0] BASE_MASK     = 32'hFFFF_FFFF,
  parameter logic [31:0] FETCH_OFFSET  = 32'h0,
  parameter int          BYTES_PER_PIX = 2,
  parameter int          RST_HACT      = 640,
  parameter int          RST_VACT      = 480
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [DATA_W/8-1:0]   bus_be,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  output logic                  bus_ack,
  output logic                  err_pulse,
  output logic                  resize_pulse,
  output logic                  inval_pulse,
  output logic                  disp_enable,
  output logic [DATA_W-1:0]     h_active,
  output logic [DATA_W-1:0]     hs_begin,
  output logic [DATA_W-1:0]     hs_end,
  output logic [DATA_W-1:0]     h_total,
  output logic [DATA_W-1:0]     v_active,
  output logic [DATA_W-1:0]     vs_begin,
  output logic [DATA_W-1:0]     vs_end,
  output logic [DATA_W-1:0]     v_total,
  output logic [DATA_W-1:0]     fetch_base,
  output logic [DATA_W-1:0]     line_stride,
  output logic [DATA_W-1:0]     burst_len,
  output logic [DATA_W-1:0]     ddc_ctl,
  output logic [DATA_W-1:0]     clk_sel
);
  localparam int STRB_W   = DATA_W / 8;
  localparam int STRIDE_SH = $clog2(BYTES_PER_PIX);

  logic [1:0] rst_sync;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  logic [IDX_W-1:0]            idx;
  logic                        wr_ok, rd_ok, bad_acc;
  logic                        res_evt, base_evt;
  logic [NREG-1:0][DATA_W-1:0] regs;

  fbctl_decode #(.ADDR_W(ADDR_W), .STRB_W(STRB_W)) u_decode (
    .addr     (bus_addr),
    .wr       (bus_wr),
    .rd       (bus_rd),
    .be       (bus_be),
    .wdata_lo (bus_wdata[ALIGN_BITS-1:0]),
    .idx      (idx),
    .wr_ok    (wr_ok),
    .rd_ok    (rd_ok),
    .bad_acc  (bad_acc)
  );

  fbctl_regbank #(
    .DATA_W(DATA_W), .BASE_MASK(BASE_MASK),
    .RST_HACT(RST_HACT), .RST_VACT(RST_VACT)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .wr_req   (bus_wr),
    .wr_ok    (wr_ok),
    .idx      (idx),
    .wdata    (bus_wdata),
    .regs_o   (regs),
    .res_evt  (res_evt),
    .base_evt (base_evt)
  );

  fbctl_rdmux #(.DATA_W(DATA_W)) u_rdmux (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .rd_req  (bus_rd),
    .rd_ok   (rd_ok),
    .idx     (idx),
    .regs    (regs),
    .rdata_o (bus_rdata)
  );

  fbctl_events u_events (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .acc      (bus_wr || bus_rd),
    .res_evt  (res_evt),
    .base_evt (base_evt),
    .bad_acc  (bad_acc),
    .ack_q    (bus_ack),
    .resize_q (resize_pulse),
    .inval_q  (inval_pulse),
    .err_q    (err_pulse)
  );

  always_comb begin
    disp_enable = ~regs[IX_CTL][0];
    h_active    = regs[IX_HACT];
    hs_begin    = regs[IX_HSB];
    hs_end      = regs[IX_HSE];
    h_total     = regs[IX_HTOT];
    v_active    = regs[IX_VACT];
    vs_begin    = regs[IX_VSB];
    vs_end      = regs[IX_VSE];
    v_total     = regs[IX_VTOT];
    burst_len   = regs[IX_BURST];
    ddc_ctl     = regs[IX_DDC];
    clk_sel     = regs[IX_CLKSEL];
    fetch_base  = regs[IX_BASE] + DATA_W'(FETCH_OFFSET);
    line_stride = regs[IX_HACT] << STRIDE_SH;
  end

  // R3
  ack_follows_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (bus_wr || bus_rd) |=> bus_ack);

  // R5
  misal_err_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (bus_wr && (&bus_be) && bus_addr == ADDR_W'(int'(IX_BASE) * 4)
      && bus_wdata[ALIGN_BITS-1:0] != '0) |=> (err_pulse && !inval_pulse));

  // R8
  resize_en_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    resize_pulse |-> disp_enable);

  // R9
  err_excl_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    err_pulse |-> !inval_pulse);
endmodule

// File: tb/fbctl_regfile_tb_top.sv
module fbctl_regfile_tb_top;
  localparam logic [31:0] MASK = 32'h00FF_FFFF;
  localparam logic [31:0] OFFS = 32'h0000_0400;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  bus_addr;
  logic        bus_wr, bus_rd;
  logic [3:0]  bus_be;
  logic [31:0] bus_wdata, bus_rdata;
  logic        bus_ack, err_pulse, resize_pulse, inval_pulse, disp_enable;
  logic [31:0] h_active, hs_begin, hs_end, h_total, v_active, vs_begin;
  logic [31:0] vs_end, v_total, fetch_base, line_stride, burst_len;
  logic [31:0] ddc_ctl, clk_sel;

  always #5 clk = ~clk;

  fbctl_regfile #(.BASE_MASK(MASK), .FETCH_OFFSET(OFFS)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack), .err_pulse(err_pulse),
    .resize_pulse(resize_pulse), .inval_pulse(inval_pulse),
    .disp_enable(disp_enable), .h_active(h_active), .hs_begin(hs_begin),
    .hs_end(hs_end), .h_total(h_total), .v_active(v_active),
    .vs_begin(vs_begin), .vs_end(vs_end), .v_total(v_total),
    .fetch_base(fetch_base), .line_stride(line_stride),
    .burst_len(burst_len), .ddc_ctl(ddc_ctl), .clk_sel(clk_sel)
  );

  int n_chk  = 0;
  int n_fail = 0;

  logic [31:0] s_rdata;
  logic        s_ack, s_err, s_res, s_inv;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input bit w, input bit r, input logic [5:0] a,
                     input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    s_rdata = bus_rdata; s_ack = bus_ack; s_err = err_pulse;
    s_res = resize_pulse; s_inv = inval_pulse;
    bus_wr = 1'b0; bus_rd = 1'b0; bus_be = 4'h0;
  endtask

  task automatic wr_w(input int ix, input logic [31:0] d);
    acc(1'b1, 1'b0, 6'(ix * 4), d, 4'hF);
  endtask

  task automatic rd_w(input int ix);
    acc(1'b0, 1'b1, 6'(ix * 4), 32'h0, 4'hF);
  endtask

  task automatic t_reset;
    chk("R1 disp_enable", {31'b0, disp_enable}, 32'h0);
    chk("R1 h_active", h_active, 32'd640);
    chk("R1 v_active", v_active, 32'd480);
    chk("R1 hs_begin", hs_begin, 32'h0);
    chk("R1 burst_len", burst_len, 32'h0);
    chk("R11 fetch_base reset", fetch_base, OFFS);
    rd_w(0);
    chk("R1 ctl read", s_rdata, 32'h1);
    chk("R3 read ack", {31'b0, s_ack}, 32'h1);
    rd_w(9);
    chk("R1 base read", s_rdata, 32'h0);
  endtask

  task automatic t_rw;
    int ixs[9] = '{2, 3, 4, 6, 7, 8, 11, 12, 13};
    foreach (ixs[k]) begin
      logic [31:0] pat;
      pat = 32'hA500_0000 | (32'(ixs[k]) * 32'h0001_1111);
      wr_w(ixs[k], pat);
      chk("R3 write ack", {31'b0, s_ack}, 32'h1);
      rd_w(ixs[k]);
      chk("R2 readback", s_rdata, pat);
    end
    chk("R2 hs_begin port", hs_begin, 32'hA502_2222);
    chk("R2 hs_end port", hs_end, 32'hA503_3333);
    chk("R2 h_total port", h_total, 32'hA504_4444);
    chk("R2 vs_begin port", vs_begin, 32'hA506_6666);
    chk("R2 vs_end port", vs_end, 32'hA507_7777);
    chk("R2 v_total port", v_total, 32'hA508_8888);
    chk("R2 burst port", burst_len, 32'hA50B_BBBB);
    chk("R2 ddc port", ddc_ctl, 32'hA50C_CCCC);
    chk("R2 clk_sel port", clk_sel, 32'hA50D_DDDD);
    @(negedge clk);
    chk("R3 ack drops", {31'b0, bus_ack}, 32'h0);
    acc(1'b1, 1'b1, 6'(3 * 4), 32'h0000_0055, 4'hF);
    chk("R3 rd with wr ignored", s_rdata, 32'h0);
    chk("R3 write stored", hs_end, 32'h55);
  endtask

  task automatic t_resize;
    wr_w(1, 32'd800);
    chk("R8 no resize while disabled", {31'b0, s_res}, 32'h0);
    chk("R2 h_active", h_active, 32'd800);
    wr_w(0, 32'h0);
    chk("R8 resize on enable", {31'b0, s_res}, 32'h1);
    chk("R8 inval on enable", {31'b0, s_inv}, 32'h1);
    chk("R4 enable high", {31'b0, disp_enable}, 32'h1);
    @(negedge clk);
    chk("R8 resize one cycle", {31'b0, resize_pulse}, 32'h0);
    wr_w(5, 32'd600);
    chk("R8 resize on v_active", {31'b0, s_res}, 32'h1);
    wr_w(2, 32'd10);
    chk("R8 no resize other word", {31'b0, s_res}, 32'h0);
    wr_w(0, 32'h1);
    chk("R8 no resize on disable", {31'b0, s_res}, 32'h0);
    chk("R4 enable low", {31'b0, disp_enable}, 32'h0);
  endtask

  task automatic t_base;
    wr_w(9, 32'h1234_5681);
    chk("R5 misaligned err", {31'b0, s_err}, 32'h1);
    chk("R5 misaligned no inval", {31'b0, s_inv}, 32'h0);
    rd_w(9);
    chk("R5 base kept", s_rdata, 32'h0);
    wr_w(9, 32'h1234_5680);
    chk("R6 inval", {31'b0, s_inv}, 32'h1);
    chk("R6 no err", {31'b0, s_err}, 32'h0);
    rd_w(9);
    chk("R6 masked base", s_rdata, 32'h0034_5680);
    chk("R11 fetch_base", fetch_base, 32'h0034_5A80);
  endtask

  task automatic t_view;
    rd_w(10);
    chk("R7 view read", s_rdata, 32'h0034_5680);
    wr_w(10, 32'h0);
    chk("R7 view write err", {31'b0, s_err}, 32'h1);
    rd_w(9);
    chk("R7 base unchanged", s_rdata, 32'h0034_5680);
  endtask

  task automatic t_illegal;
    rd_w(14);
    chk("R9 unmapped read zero", s_rdata, 32'h0);
    chk("R9 unmapped read err", {31'b0, s_err}, 32'h1);
    chk("R3 unmapped ack", {31'b0, s_ack}, 32'h1);
    wr_w(15, 32'hFFFF_FFFF);
    chk("R9 unmapped write err", {31'b0, s_err}, 32'h1);
    acc(1'b1, 1'b0, 6'(4 * 4), 32'h0000_0777, 4'h3);
    chk("R9 partial write err", {31'b0, s_err}, 32'h1);
    chk("R9 partial write no store", h_total, 32'hA504_4444);
    acc(1'b0, 1'b1, 6'(4 * 4), 32'h0, 4'h7);
    chk("R9 partial read zero", s_rdata, 32'h0);
    acc(1'b1, 1'b0, 6'(4 * 4 + 2), 32'h0000_0999, 4'hF);
    chk("R9 unaligned addr err", {31'b0, s_err}, 32'h1);
    chk("R9 unaligned no store", h_total, 32'hA504_4444);
  endtask

  task automatic t_stride;
    wr_w(1, 32'd1024);
    chk("R10 stride", line_stride, 32'd2048);
    wr_w(1, 32'd333);
    chk("R10 stride odd", line_stride, 32'd666);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_addr = '0; bus_be = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_rw();
    t_resize();
    t_base();
    t_view();
    t_illegal();
    t_stride();
    finish_run();
  end
endmodule